// File: doc/BRIEF.md
# Asymmetric Bit-Flip Bound Checker

This block decides whether a group of candidate byte values could plausibly have decayed into the observed byte values. Decay is modelled in two directions, each with its own limit. A search engine calls it once per tree level. The engine presents up to sixteen candidate/observed byte pairs, each with a lane-valid bit, together with the running flip totals carried from the path so far and one threshold per direction. It pulses `start` to begin the check.

For every valid lane the block counts two kinds of mismatched bits:
- "high-to-low" bits, where the candidate holds 1 and the observed byte holds 0;
- "low-to-high" bits, where the candidate holds 0 and the observed byte holds 1.

Two adder trees sum these counts across the lanes. Each sum is added, with saturation, to its incoming running total. Each updated total is then tested against its threshold with a strict less-than. Two cycles after `start`, the block returns the verdict and both updated totals, so the engine can store them in its checkpoint for the next level. The engine computes the thresholds, from an error rate times the number of bits checked. It also chooses which lanes are valid.

Top module: `flip_bound_check`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `done` and `compatible` read 0 and both running-total outputs read 0.
- R2: For each lane whose bit in `lane_vld` is 1, the high-to-low count is the number of bit positions where the candidate bit is 1 and the observed bit is 0. Lane i occupies bits [8i+7:8i] of `cand_bytes` and `obs_bytes`.
- R3: For each valid lane, the low-to-high count is the number of bit positions where the candidate bit is 0 and the observed bit is 1.
- R4: A lane whose valid bit is 0 adds nothing to either count, whatever its byte values are.
- R5: `run_hl_out` equals `run_hl_in` plus the high-to-low counts of all valid lanes. `run_lh_out` equals `run_lh_in` plus the low-to-high counts of all valid lanes.
- R6: `compatible` is 1 only when `run_hl_out < lim_hl` and `run_lh_out < lim_lh` both hold. A total equal to its limit fails the check.
- R7: Each updated total saturates at 2^CNT_W-1 (4095 by default) instead of wrapping.
- R8: `done` is a one-cycle pulse exactly two clock cycles after each cycle in which `start` is sampled high. A new start may be given every cycle. All operands are taken only in the start cycle, so changing them afterwards does not affect that result.
- R9: A single valid lane with candidate 0x9C and observed 0x8A yields a high-to-low count of 2 and a low-to-high count of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a check with the operands presented this cycle |
| lane_vld | input | LANES | Per-lane valid bits |
| cand_bytes | input | LANES*8 | Candidate bytes, lane i at bits [8i+7:8i] |
| obs_bytes | input | LANES*8 | Observed bytes, same lane layout |
| run_hl_in | input | CNT_W | Incoming high-to-low running total |
| run_lh_in | input | CNT_W | Incoming low-to-high running total |
| lim_hl | input | CNT_W | High-to-low threshold |
| lim_lh | input | CNT_W | Low-to-high threshold |
| done | output | 1 | Result valid pulse |
| compatible | output | 1 | Both totals strictly below their limits |
| run_hl_out | output | CNT_W | Updated high-to-low total |
| run_lh_out | output | CNT_W | Updated low-to-high total |

## Verification
A pipeline register in the wrong state shows up at the ports two cycles after the start that fed it. The symptoms are a total that is off by one lane's count, a verdict taken from a neighbouring request in a back-to-back burst, or a `done` pulse that is missing or extra. Swapped flip directions or a non-strict compare appear only with asymmetric data or with limits placed exactly on the total, so the stimulus covers one-directional patterns and limits at the total, one below it and one above it. A wrapping adder in place of a saturating one only shows near the top of the counter range, which a dedicated case drives on the next result.

// File: rtl/flipchk_pkg.sv
package flipchk_pkg;
  localparam int DEF_LANES  = 16;
  localparam int DEF_BYTE_W = 8;
  localparam int DEF_CNT_W  = 12;

  // width needed to hold values 0..max_val
  function automatic int cnt_width(input int max_val);
    return (max_val < 1) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/flipchk_lane.sv
module flipchk_lane #(
  parameter int BYTE_W = 8,
  parameter int LCNT_W = 4
) (
  input  logic              vld,
  input  logic [BYTE_W-1:0] cand,
  input  logic [BYTE_W-1:0] obs,
  output logic [LCNT_W-1:0] n_hl,
  output logic [LCNT_W-1:0] n_lh
);
  logic [BYTE_W-1:0] hl_mask, lh_mask;

  assign hl_mask = vld ? (cand & ~obs) : '0;
  assign lh_mask = vld ? (~cand & obs) : '0;

  always_comb begin
    n_hl = '0;
    n_lh = '0;
    for (int b = 0; b < BYTE_W; b++) begin
      n_hl = n_hl + LCNT_W'(hl_mask[b]);
      n_lh = n_lh + LCNT_W'(lh_mask[b]);
    end
  end
endmodule

// File: rtl/flipchk_tree.sv
module flipchk_tree #(
  parameter int N     = 16,
  parameter int IN_W  = 4,
  parameter int OUT_W = 8
) (
  input  logic [N*IN_W-1:0] leaves,
  output logic [OUT_W-1:0]  total
);
  localparam int P2 = 1 << $clog2(N);

  logic [OUT_W-1:0] node [P2];

  // pairwise reduction, one level per halving
  always_comb begin
    for (int i = 0; i < P2; i++) begin
      node[i] = (i < N) ? OUT_W'(leaves[i*IN_W +: IN_W]) : '0;
    end
    for (int w = P2 / 2; w >= 1; w = w / 2) begin
      for (int i = 0; i < w; i++) begin
        node[i] = node[2*i] + node[2*i+1];
      end
    end
    total = node[0];
  end
endmodule

// File: rtl/flipchk_bound.sv
module flipchk_bound #(
  parameter int CNT_W  = 12,
  parameter int LSUM_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld_in,
  input  logic [LSUM_W-1:0] lvl_hl,
  input  logic [LSUM_W-1:0] lvl_lh,
  input  logic [CNT_W-1:0]  prev_hl,
  input  logic [CNT_W-1:0]  prev_lh,
  input  logic [CNT_W-1:0]  thr_hl,
  input  logic [CNT_W-1:0]  thr_lh,
  output logic              vld_out,
  output logic              pass,
  output logic [CNT_W-1:0]  sum_hl,
  output logic [CNT_W-1:0]  sum_lh
);
  logic [CNT_W:0]   wide_hl, wide_lh;
  logic [CNT_W-1:0] sat_hl, sat_lh;

  assign wide_hl = {1'b0, prev_hl} + (CNT_W + 1)'(lvl_hl);
  assign wide_lh = {1'b0, prev_lh} + (CNT_W + 1)'(lvl_lh);
  assign sat_hl  = wide_hl[CNT_W] ? '1 : wide_hl[CNT_W-1:0];
  assign sat_lh  = wide_lh[CNT_W] ? '1 : wide_lh[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_out <= 1'b0;
      pass    <= 1'b0;
      sum_hl  <= '0;
      sum_lh  <= '0;
    end else begin
      vld_out <= vld_in;
      if (vld_in) begin
        pass   <= (sat_hl < thr_hl) && (sat_lh < thr_lh);
        sum_hl <= sat_hl;
        sum_lh <= sat_lh;
      end
    end
  end
endmodule

// File: rtl/flip_bound_check.sv
module flip_bound_check
  import flipchk_pkg::*;
#(
  parameter int LANES  = DEF_LANES,
  parameter int BYTE_W = DEF_BYTE_W,
  parameter int CNT_W  = DEF_CNT_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [LANES-1:0]        lane_vld,
  input  logic [LANES*BYTE_W-1:0] cand_bytes,
  input  logic [LANES*BYTE_W-1:0] obs_bytes,
  input  logic [CNT_W-1:0]        run_hl_in,
  input  logic [CNT_W-1:0]        run_lh_in,
  input  logic [CNT_W-1:0]        lim_hl,
  input  logic [CNT_W-1:0]        lim_lh,
  output logic                    done,
  output logic                    compatible,
  output logic [CNT_W-1:0]        run_hl_out,
  output logic [CNT_W-1:0]        run_lh_out
);
  localparam int LCNT_W = cnt_width(BYTE_W);
  localparam int LSUM_W = cnt_width(LANES * BYTE_W);

  logic [LANES*LCNT_W-1:0] lane_hl, lane_lh;
  logic [LSUM_W-1:0]       tree_hl, tree_lh;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    flipchk_lane #(.BYTE_W(BYTE_W), .LCNT_W(LCNT_W)) u_lane (
      .vld  (lane_vld[g]),
      .cand (cand_bytes[g*BYTE_W +: BYTE_W]),
      .obs  (obs_bytes[g*BYTE_W +: BYTE_W]),
      .n_hl (lane_hl[g*LCNT_W +: LCNT_W]),
      .n_lh (lane_lh[g*LCNT_W +: LCNT_W])
    );
  end

  flipchk_tree #(.N(LANES), .IN_W(LCNT_W), .OUT_W(LSUM_W)) u_tree_hl (
    .leaves (lane_hl),
    .total  (tree_hl)
  );

  flipchk_tree #(.N(LANES), .IN_W(LCNT_W), .OUT_W(LSUM_W)) u_tree_lh (
    .leaves (lane_lh),
    .total  (tree_lh)
  );

  // stage 1: level sums and captured operands
  logic              s1_vld;
  logic [LSUM_W-1:0] s1_hl, s1_lh;
  logic [CNT_W-1:0]  s1_prev_hl, s1_prev_lh, s1_thr_hl, s1_thr_lh;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld     <= 1'b0;
      s1_hl      <= '0;
      s1_lh      <= '0;
      s1_prev_hl <= '0;
      s1_prev_lh <= '0;
      s1_thr_hl  <= '0;
      s1_thr_lh  <= '0;
    end else begin
      s1_vld <= start;
      if (start) begin
        s1_hl      <= tree_hl;
        s1_lh      <= tree_lh;
        s1_prev_hl <= run_hl_in;
        s1_prev_lh <= run_lh_in;
        s1_thr_hl  <= lim_hl;
        s1_thr_lh  <= lim_lh;
      end
    end
  end

  // stage 2: saturating accumulate and strict compare
  flipchk_bound #(.CNT_W(CNT_W), .LSUM_W(LSUM_W)) u_bound (
    .clk     (clk),
    .rst     (rst),
    .vld_in  (s1_vld),
    .lvl_hl  (s1_hl),
    .lvl_lh  (s1_lh),
    .prev_hl (s1_prev_hl),
    .prev_lh (s1_prev_lh),
    .thr_hl  (s1_thr_hl),
    .thr_lh  (s1_thr_lh),
    .vld_out (done),
    .pass    (compatible),
    .sum_hl  (run_hl_out),
    .sum_lh  (run_lh_out)
  );
endmodule

// File: rtl/flip_bound_check_props.sv
module flip_bound_check_props #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [CNT_W-1:0] run_hl_in,
  input logic [CNT_W-1:0] run_lh_in,
  input logic [CNT_W-1:0] lim_hl,
  input logic [CNT_W-1:0] lim_lh,
  input logic             done,
  input logic             compatible,
  input logic [CNT_W-1:0] run_hl_out,
  input logic [CNT_W-1:0] run_lh_out
);
  localparam logic [CNT_W-1:0] TOP = '1;

  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    start |-> ##2 done); // R8

  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(start, 2)); // R8

  AST_TOTALS_GROW: assert property (@(posedge clk) disable iff (rst)
    done |-> (run_hl_out >= $past(run_hl_in, 2)) && (run_lh_out >= $past(run_lh_in, 2))); // R5

  AST_STRICT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    done |-> (compatible == ((run_hl_out < $past(lim_hl, 2)) && (run_lh_out < $past(lim_lh, 2))))); // R6

  AST_SATURATE_HL: assert property (@(posedge clk) disable iff (rst)
    (done && ($past(run_hl_in, 2) == TOP)) |-> (run_hl_out == TOP)); // R7

  AST_SATURATE_LH: assert property (@(posedge clk) disable iff (rst)
    (done && ($past(run_lh_in, 2) == TOP)) |-> (run_lh_out == TOP)); // R7
endmodule

bind flip_bound_check flip_bound_check_props #(.CNT_W(CNT_W)) u_props (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .run_hl_in  (run_hl_in),
  .run_lh_in  (run_lh_in),
  .lim_hl     (lim_hl),
  .lim_lh     (lim_lh),
  .done       (done),
  .compatible (compatible),
  .run_hl_out (run_hl_out),
  .run_lh_out (run_lh_out)
);

// File: tb/flip_bound_check_bench.sv
module flip_bound_check_bench;
  localparam int LANES = 16;
  localparam int BW    = 8;
  localparam int CW    = 12;
  localparam int TOPV  = (1 << CW) - 1;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 start = 1'b0;
  logic [LANES-1:0]     lane_vld = '0;
  logic [LANES*BW-1:0]  cand_bytes = '0;
  logic [LANES*BW-1:0]  obs_bytes = '0;
  logic [CW-1:0]        run_hl_in = '0, run_lh_in = '0, lim_hl = '0, lim_lh = '0;
  logic                 done, compatible;
  logic [CW-1:0]        run_hl_out, run_lh_out;

  always #5 clk = ~clk;

  flip_bound_check #(.LANES(LANES), .BYTE_W(BW), .CNT_W(CW)) u_flip_bound_check (
    .clk(clk), .rst(rst), .start(start), .lane_vld(lane_vld),
    .cand_bytes(cand_bytes), .obs_bytes(obs_bytes),
    .run_hl_in(run_hl_in), .run_lh_in(run_lh_in), .lim_hl(lim_hl), .lim_lh(lim_lh),
    .done(done), .compatible(compatible), .run_hl_out(run_hl_out), .run_lh_out(run_lh_out)
  );

  typedef struct {
    int    hl;
    int    lh;
    bit    ok;
    string tag;
  } exp_t;

  exp_t sbq[$];
  int   n_chk  = 0;
  int   n_fail = 0;

  task automatic check(input bit good, input string tag, input string what, input int act, input int expv);
    n_chk++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // reference: bit-by-bit count, then saturating add
  task automatic ref_counts(input logic [LANES-1:0] v, input logic [LANES*BW-1:0] c, o,
                            input int phl, plh, output int hl, output int lh);
    hl = phl;
    lh = plh;
    for (int i = 0; i < LANES; i++) begin
      if (v[i]) begin
        for (int b = 0; b < BW; b++) begin
          if (c[i*BW+b] && !o[i*BW+b]) hl++;
          if (!c[i*BW+b] && o[i*BW+b]) lh++;
        end
      end
    end
    if (hl > TOPV) hl = TOPV;
    if (lh > TOPV) lh = TOPV;
  endtask

  task automatic push_case(input logic [LANES-1:0] v, input logic [LANES*BW-1:0] c, o,
                           input int phl, plh, thl, tlh, input string tag);
    exp_t e;
    int hl, lh;
    ref_counts(v, c, o, phl, plh, hl, lh);
    e.hl  = hl;
    e.lh  = lh;
    e.ok  = (hl < thl) && (lh < tlh);
    e.tag = tag;
    @(negedge clk);
    start      = 1'b1;
    lane_vld   = v;
    cand_bytes = c;
    obs_bytes  = o;
    run_hl_in  = CW'(phl);
    run_lh_in  = CW'(plh);
    lim_hl     = CW'(thl);
    lim_lh     = CW'(tlh);
    sbq.push_back(e);
  endtask

  // deassert start and scramble operands (R8: must not affect results in flight)
  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      start      = 1'b0;
      lane_vld   = LANES'($urandom);
      for (int i = 0; i < LANES; i++) begin
        cand_bytes[i*BW +: BW] = BW'($urandom);
        obs_bytes[i*BW +: BW]  = BW'($urandom);
      end
      run_hl_in = CW'($urandom);
      run_lh_in = CW'($urandom);
      lim_hl    = CW'($urandom);
      lim_lh    = CW'($urandom);
    end
  endtask

  // monitor: pop scoreboard on every result
  always @(negedge clk) begin
    if (!rst && done) begin
      if (sbq.size() == 0) begin
        check(1'b0, "R8", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check(int'(run_hl_out) == e.hl, e.tag, "high-to-low total", int'(run_hl_out), e.hl);
        check(int'(run_lh_out) == e.lh, e.tag, "low-to-high total", int'(run_lh_out), e.lh);
        check(compatible == e.ok, e.tag, "compatible", int'(compatible), int'(e.ok));
      end
    end
  end

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R8", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [LANES*BW-1:0] c, o;
    logic [LANES-1:0]    v;
    int hl, lh;

    repeat (3) @(negedge clk);
    // R1: reset state
    check(done == 1'b0 && compatible == 1'b0, "R1", "flags in reset", int'({done, compatible}), 0);
    check(run_hl_out == '0 && run_lh_out == '0, "R1", "totals in reset", int'(run_hl_out) + int'(run_lh_out), 0);
    rst = 1'b0;
    @(negedge clk);
    check(done == 1'b0 && run_hl_out == '0, "R1", "after reset", int'(done), 0);

    // R9: 0x9C vs 0x8A on lane 0 -> 2 and 1
    c = '0; o = '0;
    c[7:0] = 8'h9C; o[7:0] = 8'h8A;
    push_case(16'h0001, c, o, 0, 0, 3, 2, "R9");
    idle(3);

    // R2: all-ones candidate, all-zero observed, all lanes
    push_case('1, '1, '0, 0, 0, 200, 1, "R2");
    // R3: reverse direction
    push_case('1, '0, '1, 0, 0, 1, 200, "R3");
    // R4: no valid lanes, heavy mismatch data
    push_case('0, '1, '0, 7, 9, 8, 10, "R4");
    // R4: only odd lanes valid
    push_case(16'hAAAA, '1, '0, 0, 0, 65, 1, "R4");
    idle(3);

    // R5: running totals added to level counts
    push_case(16'h0001, c, o, 100, 50, 200, 200, "R5");
    // R6: boundary, lane 0 FF vs 00 -> hl 8, lh 0
    v = 16'h0001; c = '0; o = '0; c[7:0] = 8'hFF;
    push_case(v, c, o, 0, 0, 8, 1, "R6");   // equal -> fail
    push_case(v, c, o, 0, 0, 9, 1, "R6");   // above -> pass
    push_case(v, c, o, 0, 0, 7, 1, "R6");   // below -> fail
    push_case(v, c, o, 0, 0, 9, 0, "R6");   // lh 0 not below 0 -> fail
    push_case(v, o, c, 0, 0, 1, 8, "R6");   // lh 8 equal -> fail
    push_case(v, o, c, 0, 0, 1, 9, "R6");   // lh 8 below 9 -> pass
    idle(3);

    // R7: saturation
    push_case('1, '1, '0, TOPV - 5, 0, TOPV, 1, "R7");
    push_case('1, '0, '1, 0, TOPV, 1, TOPV, "R7");
    idle(3);

    // R8: back-to-back random, limits around the reference total
    for (int n = 0; n < 60; n++) begin
      int phl, plh, dh, dl;
      v = LANES'($urandom);
      for (int i = 0; i < LANES; i++) begin
        c[i*BW +: BW] = BW'($urandom);
        o[i*BW +: BW] = BW'($urandom);
      end
      phl = $urandom_range(0, 300);
      plh = $urandom_range(0, 300);
      ref_counts(v, c, o, phl, plh, hl, lh);
      dh = $urandom_range(0, 2) - 1;
      dl = $urandom_range(0, 2) - 1;
      push_case(v, c, o, phl, plh, hl + dh, lh + dl, "R8");
      if (n % 7 == 6) idle(1);
    end
    idle(4);
    check(sbq.size() == 0, "R8", "results outstanding", sbq.size(), 0);
    finish_run();
  end
endmodule